// File: doc/BRIEF.md
# Early-Late Vote CDR Phase Controller

This block is the digital loop filter of a bang-bang clock-data-recovery receiver. Each vote clock a phase detector reports whether the data edge arrived early or late relative to the sampling clock. The controller accumulates these votes. When the late and early totals differ by a programmable threshold, it sends one phase-step command to a phase interpolator. After a step the voter rests for a programmable number of vote clocks so that the phase change can settle.

An optional second-order path integrates the first-order decisions into a signed frequency estimate. It converts that estimate into extra phase steps in one of two ways: a first-order sigma-delta accumulator, or a rate divider that fires once every fixed number of votes. A fast-lock option shortens acquisition, and a polarity stage can invert the received data word. The inversion is taken from a pin or from a register bit, depending on an override bit.

Top module: `cdr_phase_ctrl`

## Requirements
- R1: `step_up` and `step_down` are registered one-cycle pulses. They are never high together and are low during and straight after reset. A vote sampled at one rising edge affects the pulses in the following clock cycle. A late majority gives `step_up`; an early majority gives `step_down`.
- R2: A first-order step is issued when the absolute difference between the accumulated late and early counts reaches the effective threshold. Outside fast lock the effective threshold is `thr_cfg`, with 0 treated as 1.
- R3: A first-order step clears both accumulated counts to zero, so votes taken before the step do not count towards the next one.
- R4: A vote clock with `vote_early` and `vote_late` both high adds to neither count. A cycle with `vote_valid` low is not a vote clock.
- R5: Outside fast lock, the `blank_cfg` vote clocks that follow a first-order step are ignored. Voting resumes on the vote clock after them.
- R6: While `fastlock_en` is 1 and fewer than 16 first-order steps have occurred since reset, the effective threshold is `thr_cfg` shifted right by one (minimum 1) and no blanking follows a step. After the 16th step the normal threshold and blanking apply.
- R7: With `so2_en` high, each first-order up step adds 2^`stepcnt_cfg` to a signed frequency integrator and each down step subtracts it. The integrator saturates at ±127. With `so2_en` low the integrator and both converters stay at zero and inject nothing.
- R8: With `sdm_mode`=1, each vote clock adds the integrator value shifted left by `lbw_cfg` to an 8-bit phase accumulator. A sum of 256 or more injects an up step, a sum below zero injects a down step, and the accumulator keeps the sum modulo 256. The integrator value added is the one held before that vote clock.
- R9: With `sdm_mode`=0 and a nonzero integrator, one step with the sign of the integrator is injected every 128 − |integrator| vote clocks.
- R10: Injected steps neither clear the counts nor start blanking. When an injected step and a first-order step arrive in the same cycle, the same direction gives a single pulse and opposite directions give no pulse.
- R11: `rx_out` equals `rx_in` with every bit inverted when the selected inversion control is 1. The control is `inv_reg` when `inv_ovrd`=1, and `inv_pin` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vote_valid | input | 1 | Marks a vote clock |
| vote_early | input | 1 | Early indication from the phase detector |
| vote_late | input | 1 | Late indication from the phase detector |
| thr_cfg | input | 3 | Vote-difference threshold |
| blank_cfg | input | 3 | Vote clocks ignored after a step |
| fastlock_en | input | 1 | Fast-lock enable |
| so2_en | input | 1 | Second-order path enable |
| sdm_mode | input | 1 | 1: sigma-delta conversion, 0: rate divider |
| stepcnt_cfg | input | 2 | Integrator gain exponent |
| lbw_cfg | input | 2 | Sigma-delta increment shift |
| rx_in | input | 8 | Received data word |
| inv_pin | input | 1 | Inversion control from pin |
| inv_ovrd | input | 1 | Selects `inv_reg` over `inv_pin` |
| inv_reg | input | 1 | Inversion control from register |
| rx_out | output | 8 | Data word after polarity stage |
| step_up | output | 1 | Advance phase pulse |
| step_down | output | 1 | Retard phase pulse |

## Verification
The voter is exercised with several vote streams. Late runs and early runs check direction. Mixed streams whose net difference climbs slowly show that the counts are netted rather than counted per side. Tied and invalid vote clocks must move nothing. A stream that resumes after a step shows that the counts were cleared. Fast lock is told apart by its halved threshold and missing blanking across the first sixteen steps and the change afterwards. The second-order path is identified by the spacing of injected pulses during idle votes: 64 versus 16 votes for two sigma-delta shifts, an immediate underflow for a negative estimate, and a 124-vote period for the rate divider. Coinciding opposite steps must cancel.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_dir_e;

    typedef struct packed {
        logic up;
        logic dn;
    } step_pair_t;

endpackage

// File: rtl/cdr_rx_polarity.sv
module cdr_rx_polarity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_in,
    input  logic              inv_pin,
    input  logic              inv_ovrd,
    input  logic              inv_reg,
    output logic [DATA_W-1:0] rx_out
);

    logic inv_sel;

    always_comb begin
        inv_sel = inv_ovrd ? inv_reg : inv_pin;
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign rx_out[b] = rx_in[b] ^ inv_sel;
    end

endmodule

// File: rtl/cdr_vote_filter.sv
module cdr_vote_filter
    import cdr_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int THR_W    = 3,
    parameter int STL_W    = 3,
    parameter int FL_STEPS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vote_valid,
    input  logic             early,
    input  logic             late,
    input  logic [THR_W-1:0] thr_cfg,
    input  logic [STL_W-1:0] stl_cfg,
    input  logic             fastlock_en,
    output step_dir_e        dir_o
);

    localparam int FLC_W = $clog2(FL_STEPS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] ecnt;
        logic [CNT_W-1:0] lcnt;
        logic [STL_W-1:0] blank;
        logic [FLC_W-1:0] nsteps;
    } vf_state_t;

    vf_state_t        st_q, st_d;
    step_dir_e        dir_d;
    logic             vote_act, e_hit, l_hit, fl_act;
    logic [CNT_W-1:0] e_new, l_new, diff;
    logic [THR_W-1:0] thr_half, thr_eff;

    always_comb begin
        st_d     = st_q;
        dir_d    = STEP_NONE;
        vote_act = vote_valid && (st_q.blank == '0);
        e_hit    = vote_act && early && !late;
        l_hit    = vote_act && late && !early;
        e_new    = (e_hit && st_q.ecnt != CNT_MAX) ? st_q.ecnt + 1'b1 : st_q.ecnt;
        l_new    = (l_hit && st_q.lcnt != CNT_MAX) ? st_q.lcnt + 1'b1 : st_q.lcnt;
        fl_act   = fastlock_en && (st_q.nsteps < FLC_W'(FL_STEPS));
        thr_half = thr_cfg >> 1;
        if (fl_act) begin
            thr_eff = (thr_half == '0) ? THR_W'(1) : thr_half;
        end else begin
            thr_eff = (thr_cfg == '0) ? THR_W'(1) : thr_cfg;
        end
        diff = (l_new >= e_new) ? (l_new - e_new) : (e_new - l_new);

        st_d.ecnt = e_new;
        st_d.lcnt = l_new;
        if (vote_act && (diff >= CNT_W'(thr_eff))) begin
            dir_d      = (l_new > e_new) ? STEP_UP : STEP_DN;
            st_d.ecnt  = '0;
            st_d.lcnt  = '0;
            st_d.blank = fl_act ? '0 : stl_cfg;
            if (st_q.nsteps < FLC_W'(FL_STEPS)) begin
                st_d.nsteps = st_q.nsteps + 1'b1;
            end
        end else if (vote_valid && (st_q.blank != '0)) begin
            st_d.blank = st_q.blank - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_o = dir_d;

    // R5: no decision while the voter is blanked
    a_r5_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.blank != '0) |-> (dir_d == STEP_NONE));

    // R3: counts are zero after any first-order step
    a_r3_clear_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_d != STEP_NONE) |=> (st_q.ecnt == '0 && st_q.lcnt == '0));

    // R4: a tied vote changes neither count
    a_r4_tie_no_vote: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_valid && early && late && dir_d == STEP_NONE)
        |=> ($stable(st_q.ecnt) && $stable(st_q.lcnt)));

    // R4: a cycle that is not a vote clock changes neither count
    a_r4_invalid_no_vote: assert property (@(posedge clk) disable iff (!rst_n)
        (!vote_valid) |=> ($stable(st_q.ecnt) && $stable(st_q.lcnt)));

endmodule

// File: rtl/cdr_freq_path.sv
module cdr_freq_path
    import cdr_pkg::*;
#(
    parameter int INT_W = 8,
    parameter int PH_W  = 8,
    parameter int SC_W  = 2,
    parameter int BW_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vote_valid,
    input  logic            so2_en,
    input  logic            sdm_mode,
    input  logic [SC_W-1:0] stepcnt_cfg,
    input  logic [BW_W-1:0] lbw_cfg,
    input  step_dir_e       dir_i,
    output step_dir_e       inj_o
);

    localparam int SUM_W = INT_W + PH_W + (1 << BW_W) + 1;
    localparam logic signed [INT_W+1:0] LIM  = (INT_W + 2)'(2 ** (INT_W - 1) - 1);
    localparam logic signed [INT_W+1:0] NLIM = -LIM;
    localparam logic signed [SUM_W-1:0] PH_MOD = SUM_W'(2 ** PH_W);
    localparam logic [INT_W-1:0] RATE_SPAN = INT_W'(2 ** (INT_W - 1));
    localparam logic signed [INT_W-1:0] INT_MIN = {1'b1, {(INT_W - 1){1'b0}}};

    typedef struct packed {
        logic signed [INT_W-1:0] integ;
        logic [PH_W-1:0]         acc;
        logic [INT_W-1:0]        rcnt;
    } fp_state_t;

    fp_state_t               st_q, st_d;
    step_dir_e               inj_d;
    logic signed [INT_W+1:0] i_ext, i_gain, i_next;
    logic signed [SUM_W-1:0] inc, sum;
    logic [INT_W-1:0]        mag, period, rcnt_inc;

    always_comb begin
        st_d   = st_q;
        inj_d  = STEP_NONE;
        i_ext  = {{2{st_q.integ[INT_W-1]}}, st_q.integ};
        i_gain = (INT_W + 2)'(1) <<< stepcnt_cfg;
        i_next = i_ext;
        if (dir_i == STEP_UP) begin
            i_next = i_ext + i_gain;
        end else if (dir_i == STEP_DN) begin
            i_next = i_ext - i_gain;
        end
        if (i_next > LIM) begin
            i_next = LIM;
        end else if (i_next < NLIM) begin
            i_next = NLIM;
        end

        inc      = SUM_W'(st_q.integ) <<< lbw_cfg;
        sum      = $signed({{(SUM_W - PH_W){1'b0}}, st_q.acc}) + inc;
        mag      = st_q.integ[INT_W-1] ? (~st_q.integ + 1'b1) : st_q.integ;
        period   = RATE_SPAN - mag;
        rcnt_inc = st_q.rcnt + 1'b1;

        if (!so2_en) begin
            st_d = '0;
        end else begin
            st_d.integ = i_next[INT_W-1:0];
            if (vote_valid) begin
                if (sdm_mode) begin
                    st_d.rcnt = '0;
                    st_d.acc  = sum[PH_W-1:0];
                    if (sum < 0) begin
                        inj_d = STEP_DN;
                    end else if (sum >= PH_MOD) begin
                        inj_d = STEP_UP;
                    end
                end else begin
                    st_d.acc = '0;
                    if (mag == '0) begin
                        st_d.rcnt = '0;
                    end else if (rcnt_inc >= period) begin
                        st_d.rcnt = '0;
                        inj_d     = st_q.integ[INT_W-1] ? STEP_DN : STEP_UP;
                    end else begin
                        st_d.rcnt = rcnt_inc;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inj_o = inj_d;

    // R7: the integrator stays inside the symmetric range
    a_r7_integ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.integ != INT_MIN);

    // R8 / R9: a zero frequency estimate injects nothing
    a_r9_zero_estimate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.integ == '0) |-> (inj_d == STEP_NONE));

    // R7: with the path off nothing is injected
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!so2_en) |-> (inj_d == STEP_NONE));

endmodule

// File: rtl/cdr_phase_ctrl.sv
module cdr_phase_ctrl
    import cdr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 4,
    parameter int THR_W    = 3,
    parameter int STL_W    = 3,
    parameter int FL_STEPS = 16,
    parameter int INT_W    = 8,
    parameter int PH_W     = 8,
    parameter int SC_W     = 2,
    parameter int BW_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vote_valid,
    input  logic              vote_early,
    input  logic              vote_late,
    input  logic [THR_W-1:0]  thr_cfg,
    input  logic [STL_W-1:0]  blank_cfg,
    input  logic              fastlock_en,
    input  logic              so2_en,
    input  logic              sdm_mode,
    input  logic [SC_W-1:0]   stepcnt_cfg,
    input  logic [BW_W-1:0]   lbw_cfg,
    input  logic [DATA_W-1:0] rx_in,
    input  logic              inv_pin,
    input  logic              inv_ovrd,
    input  logic              inv_reg,
    output logic [DATA_W-1:0] rx_out,
    output logic              step_up,
    output logic              step_down
);

    step_dir_e  fo_dir, inj_dir;
    step_pair_t out_d, out_q;
    logic       any_up, any_dn;

    cdr_vote_filter #(
        .CNT_W(CNT_W), .THR_W(THR_W), .STL_W(STL_W), .FL_STEPS(FL_STEPS)
    ) u_vote (
        .clk(clk), .rst_n(rst_n), .vote_valid(vote_valid),
        .early(vote_early), .late(vote_late),
        .thr_cfg(thr_cfg), .stl_cfg(blank_cfg), .fastlock_en(fastlock_en),
        .dir_o(fo_dir)
    );

    cdr_freq_path #(
        .INT_W(INT_W), .PH_W(PH_W), .SC_W(SC_W), .BW_W(BW_W)
    ) u_freq (
        .clk(clk), .rst_n(rst_n), .vote_valid(vote_valid),
        .so2_en(so2_en), .sdm_mode(sdm_mode),
        .stepcnt_cfg(stepcnt_cfg), .lbw_cfg(lbw_cfg),
        .dir_i(fo_dir), .inj_o(inj_dir)
    );

    cdr_rx_polarity #(.DATA_W(DATA_W)) u_pol (
        .rx_in(rx_in), .inv_pin(inv_pin), .inv_ovrd(inv_ovrd),
        .inv_reg(inv_reg), .rx_out(rx_out)
    );

    always_comb begin
        any_up   = (fo_dir == STEP_UP) || (inj_dir == STEP_UP);
        any_dn   = (fo_dir == STEP_DN) || (inj_dir == STEP_DN);
        out_d.up = any_up && !any_dn;
        out_d.dn = any_dn && !any_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign step_up   = out_q.up;
    assign step_down = out_q.dn;

    // R1: the two pulses are exclusive
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_down));

    // R10: opposite first-order and injected steps cancel
    a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        ((fo_dir == STEP_UP && inj_dir == STEP_DN) ||
         (fo_dir == STEP_DN && inj_dir == STEP_UP))
        |=> (!step_up && !step_down));

    // R1: a late-majority step becomes an up pulse in the next cycle
    a_r1_up_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (fo_dir == STEP_UP && inj_dir != STEP_DN) |=> step_up);

endmodule

// File: tb/cdr_phase_ctrl_test.sv
`timescale 1ns/1ps
module cdr_phase_ctrl_test;

    typedef struct {
        logic  up;
        logic  dn;
        string req;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vote_valid = 1'b0, vote_early = 1'b0, vote_late = 1'b0;
    logic [2:0] thr_cfg = 3'd1, blank_cfg = 3'd0;
    logic       fastlock_en = 1'b0, so2_en = 1'b0, sdm_mode = 1'b1;
    logic [1:0] stepcnt_cfg = 2'd0, lbw_cfg = 2'd0;
    logic [7:0] rx_in = 8'h00;
    logic       inv_pin = 1'b0, inv_ovrd = 1'b0, inv_reg = 1'b0;
    logic [7:0] rx_out;
    logic       step_up, step_down;

    int checks = 0;
    int fails = 0;
    bit reported = 0;
    exp_item_t exp_q[$];

    always #2 clk = ~clk;

    cdr_phase_ctrl uut (
        .clk(clk), .rst_n(rst_n), .vote_valid(vote_valid),
        .vote_early(vote_early), .vote_late(vote_late),
        .thr_cfg(thr_cfg), .blank_cfg(blank_cfg), .fastlock_en(fastlock_en),
        .so2_en(so2_en), .sdm_mode(sdm_mode), .stepcnt_cfg(stepcnt_cfg),
        .lbw_cfg(lbw_cfg), .rx_in(rx_in), .inv_pin(inv_pin),
        .inv_ovrd(inv_ovrd), .inv_reg(inv_reg), .rx_out(rx_out),
        .step_up(step_up), .step_down(step_down)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    task automatic check_val(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops one expectation per driven cycle
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            checks++;
            if (step_up !== it.up || step_down !== it.dn) begin
                fails++;
                $display("FAIL %s: actual up=%b dn=%b expected up=%b dn=%b",
                         it.req, step_up, step_down, it.up, it.dn);
            end
        end
    end

    task automatic vote(input logic e, input logic l, input logic eu, input logic ed,
                        input string req);
        exp_item_t it;
        @(negedge clk);
        vote_valid = 1'b1; vote_early = e; vote_late = l;
        it.up = eu; it.dn = ed; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic no_vote(input logic l, input string req);
        exp_item_t it;
        @(negedge clk);
        vote_valid = 1'b0; vote_early = 1'b0; vote_late = l;
        it.up = 1'b0; it.dn = 1'b0; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) vote(1'b0, 1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic settle();
        @(negedge clk);
        vote_valid = 1'b0; vote_early = 1'b0; vote_late = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic do_reset();
        settle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_val("R1 reset", {6'd0, step_up, step_down}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 after reset", {6'd0, step_up, step_down}, 8'd0);

        // R1 direction, thr=1 no blanking
        thr_cfg = 3'd1; blank_cfg = 3'd0;
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R1 late->up");
        vote(1'b1, 1'b0, 1'b0, 1'b1, "R1 early->down");
        idle(3, "R1 idle");

        // R2 netted threshold of 3
        settle(); do_reset(); thr_cfg = 3'd3;
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R2");
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R2");
        vote(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R2");
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R2 diff3 up");
        vote(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        vote(1'b1, 1'b0, 1'b0, 1'b0, "R2");
        vote(1'b1, 1'b0, 1'b0, 1'b1, "R2 diff3 down");
        // R2 zero threshold acts as one
        settle(); thr_cfg = 3'd0;
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R2 thr0");

        // R3 counts cleared after a step
        settle(); do_reset(); thr_cfg = 3'd2;
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R3");
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R3 first");
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R3 cleared");
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R3 second");

        // R4 tied and invalid votes
        settle(); do_reset(); thr_cfg = 3'd1;
        vote(1'b1, 1'b1, 1'b0, 1'b0, "R4 tie");
        vote(1'b1, 1'b1, 1'b0, 1'b0, "R4 tie");
        no_vote(1'b1, "R4 invalid");
        no_vote(1'b1, "R4 invalid");
        vote(1'b1, 1'b0, 1'b0, 1'b1, "R4 then early");

        // R5 blanking of 3 vote clocks
        settle(); do_reset(); thr_cfg = 3'd1; blank_cfg = 3'd3;
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R5 step");
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R5 blanked");
        no_vote(1'b1, "R5 non-vote");
        vote(1'b1, 1'b0, 1'b0, 1'b0, "R5 blanked");
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R5 blanked");
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R5 resumed");

        // R6 fast lock: thr 4 -> 2, no blanking for 16 steps
        settle(); do_reset(); thr_cfg = 3'd4; blank_cfg = 3'd3; fastlock_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            vote(1'b0, 1'b1, 1'b0, 1'b0, "R6 fast");
            vote(1'b0, 1'b1, 1'b1, 1'b0, "R6 fast step");
        end
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R6 normal");
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R6 normal");
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R6 normal");
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R6 normal step");
        for (int k = 0; k < 3; k++) vote(1'b0, 1'b1, 1'b0, 1'b0, "R6 blanked");
        for (int k = 0; k < 3; k++) vote(1'b0, 1'b1, 1'b0, 1'b0, "R6 normal");
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R6 normal step");
        settle(); fastlock_en = 1'b0; blank_cfg = 3'd0;

        // R7 path off: no injection after a step
        do_reset(); thr_cfg = 3'd1; so2_en = 1'b0;
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R7 off step");
        idle(150, "R7 off quiet");

        // R8 sigma-delta, integ=4: overflow after 64 votes, lbw=2 every 16
        settle(); do_reset(); so2_en = 1'b1; sdm_mode = 1'b1; stepcnt_cfg = 2'd2;
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R7 step");
        idle(63, "R8 sdm");
        vote(1'b0, 1'b0, 1'b1, 1'b0, "R8 overflow");
        settle(); lbw_cfg = 2'd2;
        idle(15, "R8 sdm lbw");
        vote(1'b0, 1'b0, 1'b1, 1'b0, "R8 overflow lbw");
        settle(); lbw_cfg = 2'd0;

        // R8 negative estimate underflows at once
        do_reset();
        vote(1'b1, 1'b0, 1'b0, 1'b1, "R7 down step");
        vote(1'b0, 1'b0, 1'b0, 1'b1, "R8 underflow");
        idle(63, "R8 sdm neg");
        vote(1'b0, 1'b0, 1'b0, 1'b1, "R8 underflow again");

        // R9 rate divider, integ=4: period 124; stepcnt 3 -> 8: period 120
        settle(); do_reset(); sdm_mode = 1'b0;
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R7 step");
        idle(123, "R9 rate");
        vote(1'b0, 1'b0, 1'b1, 1'b0, "R9 inject");
        idle(123, "R9 rate");
        vote(1'b0, 1'b0, 1'b1, 1'b0, "R9 inject");
        settle(); do_reset(); stepcnt_cfg = 2'd3;
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R7 step gain8");
        idle(119, "R9 rate8");
        vote(1'b0, 1'b0, 1'b1, 1'b0, "R9 inject gain8");

        // R10 opposite coincident steps cancel
        settle(); do_reset(); sdm_mode = 1'b1; stepcnt_cfg = 2'd2;
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R10 setup");
        idle(63, "R10 sdm");
        vote(1'b1, 1'b0, 1'b0, 1'b0, "R10 cancel");
        idle(80, "R10 estimate back to zero");
        // R10 same-direction coincidence: single pulse, counts not cleared by injection
        settle(); do_reset(); thr_cfg = 3'd2;
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R10");
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R10 step");
        idle(62, "R10 sdm");
        vote(1'b0, 1'b1, 1'b0, 1'b0, "R10 vote pending");
        vote(1'b0, 1'b1, 1'b1, 1'b0, "R10 agree single");
        settle(); so2_en = 1'b0;

        // R11 polarity
        rx_in = 8'hA5; inv_ovrd = 1'b0; inv_pin = 1'b0; inv_reg = 1'b1;
        #1 check_val("R11 pin=0", rx_out, 8'hA5);
        inv_pin = 1'b1;
        #1 check_val("R11 pin=1", rx_out, 8'h5A);
        inv_ovrd = 1'b1; inv_reg = 1'b0;
        #1 check_val("R11 override reg=0", rx_out, 8'hA5);
        inv_reg = 1'b1; inv_pin = 1'b0;
        #1 check_val("R11 override reg=1", rx_out, 8'h5A);

        settle();
        report();
    end

endmodule